// File: doc/BRIEF.md
# Clock Lane Line-State Sequencer

This block sequences the clock lane of a two-wire serial camera/display PHY between its low-power Stop state and continuous high-speed clocking. A request input asks for the high-speed clock to run or to stop. Per-lane flags report whether each associated data lane is currently in low power. The block drives an encoded line state for the analog driver and a go flag. The go flag tells the data lanes that the clock has been running long enough for them to start a burst.

Every interval is a count of cycles of the local timing clock, taken from a configuration input. The count is captured into a down-counter when the matching state is entered, and the state advances once that counter runs out. A programmed count of zero behaves as one cycle. Entry follows a fixed order: Stop, then a request state, then a bridge state, then a driven-zero state, then toggling. Exit follows the reverse order, through a trail state and a guarded Stop interval. Conversion from time to cycles, analog drivers and termination lie outside the block.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: After reset, `line_state` is LP-11 (code 0) and `data_go` is 0. Line codes are: 0 = LP-11, 1 = LP-01, 2 = LP-00, 3 = HS-0, 4 = HS toggling.
- R2: While idle in LP-11 with `hs_req` low, the line stays LP-11. When `hs_req` is high in idle LP-11, the line shows LP-01 in the next cycle.
- R3: LP-01 lasts max(`t_lpx`,1) cycles and is followed by LP-00.
- R4: LP-00 lasts max(`t_prep`,1) cycles and is followed directly by HS-0.
- R5: HS-0 on entry lasts max(`t_zero`,1) cycles and is followed by toggling.
- R6: Toggling runs with `data_go` low for max(`t_pre`,1) cycles, and then `data_go` rises.
- R7: `data_go` is high only while the line toggles. It falls in the cycle after `hs_req` is seen low during running.
- R8: Toggling continues while any `data_lp` bit is 0 (that lane is in high speed). Once all bits are 1, toggling lasts exactly max(`t_post`,1) more cycles.
- R9: After the post interval, HS-0 lasts max(`t_trail`,1) cycles, and the line then returns to LP-11.
- R10: After trail, LP-11 is held for max(`t_exit`,1) cycles, during which a request is ignored. With `hs_req` held high, LP-01 appears after max(`t_exit`,1)+1 LP-11 cycles.
- R11: Each interval input is sampled only when its state is entered. Changing it while that state is in progress has no effect on that state's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req | input | 1 | High: run HS clock; low: stop it |
| data_lp | input | LANES | Per data lane, 1 = lane is in low power |
| t_lpx | input | CNT_W | LP-01 interval in cycles |
| t_prep | input | CNT_W | LP-00 prepare interval in cycles |
| t_zero | input | CNT_W | HS-0 interval before toggling |
| t_pre | input | CNT_W | Toggling before data lanes may start |
| t_post | input | CNT_W | Toggling after all lanes are low power |
| t_trail | input | CNT_W | HS-0 interval after the last clock bit |
| t_exit | input | CNT_W | Guarded LP-11 interval after a burst |
| line_state | output | 3 | Encoded line state (codes in R1) |
| data_go | output | 1 | Data lanes may begin a burst |

## Verification
A state register or interval counter that goes wrong shows up at once on `line_state`. A missed counter load or an early expiry makes one of the seven phases longer or shorter than max(N,1) by at least one cycle. A skipped state breaks the fixed code order in the cycle where the skip happens. A fault in the lane-gating path shows up as the trail HS-0 starting while a data lane still reports high speed, or as a post phase of the wrong length counted from the cycle the last lane returns to low power. A fault in the go flag is seen within one cycle of the run phase starting or ending.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

   typedef enum logic [3:0] {
      S_IDLE, S_REQ, S_BRIDGE, S_ZERO, S_LEAD,
      S_RUN, S_TAIL, S_TRAIL, S_GUARD
   } seq_state_e;

   typedef enum logic [2:0] {
      LN_LP11  = 3'd0,
      LN_LP01  = 3'd1,
      LN_LP00  = 3'd2,
      LN_HS0   = 3'd3,
      LN_HSTOG = 3'd4
   } line_code_e;

   function automatic line_code_e state_to_line(input seq_state_e s);
      case (s)
         S_REQ:                   return LN_LP01;
         S_BRIDGE:                return LN_LP00;
         S_ZERO, S_TRAIL:         return LN_HS0;
         S_LEAD, S_RUN, S_TAIL:   return LN_HSTOG;
         default:                 return LN_LP11;
      endcase
   endfunction

endpackage

// File: rtl/cls_interval_timer.sv
module cls_interval_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   // a count of N spans N cycles; zero behaves as one cycle
   assign expired = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/cls_lane_monitor.sv
module cls_lane_monitor #(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] data_lp,
   output logic             all_lp
);
   generate
      if (LANES == 1) begin : g_single
         assign all_lp = data_lp[0];
      end else begin : g_multi
         logic [LANES-1:0] chain;
         assign chain[0] = data_lp[0];
         for (genvar i = 1; i < LANES; i++) begin : g_and
            assign chain[i] = chain[i-1] & data_lp[i];
         end
         assign all_lp = chain[LANES-1];
      end
   endgenerate
endmodule

// File: rtl/cls_fsm.sv
module cls_fsm
   import clk_lane_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_req,
   input  logic             all_lp,
   input  logic             expired,
   input  logic [CNT_W-1:0] t_lpx,
   input  logic [CNT_W-1:0] t_prep,
   input  logic [CNT_W-1:0] t_zero,
   input  logic [CNT_W-1:0] t_pre,
   input  logic [CNT_W-1:0] t_post,
   input  logic [CNT_W-1:0] t_trail,
   input  logic [CNT_W-1:0] t_exit,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output seq_state_e       state_q,
   output seq_state_e       state_d
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      case (state_q)
         S_IDLE: if (hs_req) begin
            state_d = S_REQ;    load = 1'b1; load_val = t_lpx;
         end
         S_REQ: if (expired) begin
            state_d = S_BRIDGE; load = 1'b1; load_val = t_prep;
         end
         S_BRIDGE: if (expired) begin
            state_d = S_ZERO;   load = 1'b1; load_val = t_zero;
         end
         S_ZERO: if (expired) begin
            state_d = S_LEAD;   load = 1'b1; load_val = t_pre;
         end
         S_LEAD: if (expired) state_d = S_RUN;
         S_RUN: if (!hs_req) begin
            state_d = S_TAIL;   load = 1'b1; load_val = t_post;
         end
         S_TAIL: begin
            if (!all_lp) begin
               load = 1'b1; load_val = t_post;   // restart post window
            end else if (expired) begin
               state_d = S_TRAIL; load = 1'b1; load_val = t_trail;
            end
         end
         S_TRAIL: if (expired) begin
            state_d = S_GUARD;  load = 1'b1; load_val = t_exit;
         end
         S_GUARD: if (expired) state_d = S_IDLE;
         default: state_d = S_IDLE;
      endcase
   end
endmodule

// File: rtl/cls_out_stage.sv
module cls_out_stage
   import clk_lane_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e state_q,
   input  seq_state_e state_d,
   output logic [2:0] line_state,
   output logic       data_go
);
   generate
      if (REG_OUT) begin : g_reg
         // register the decode of the next state: same timing, no glitches
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_state <= LN_LP11;
               data_go    <= 1'b0;
            end else begin
               line_state <= state_to_line(state_d);
               data_go    <= (state_d == S_RUN);
            end
         end
      end else begin : g_comb
         assign line_state = state_to_line(state_q);
         assign data_go    = (state_q == S_RUN);
      end
   endgenerate
endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
   import clk_lane_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int CNT_W   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_req,
   input  logic [LANES-1:0] data_lp,
   input  logic [CNT_W-1:0] t_lpx,
   input  logic [CNT_W-1:0] t_prep,
   input  logic [CNT_W-1:0] t_zero,
   input  logic [CNT_W-1:0] t_pre,
   input  logic [CNT_W-1:0] t_post,
   input  logic [CNT_W-1:0] t_trail,
   input  logic [CNT_W-1:0] t_exit,
   output logic [2:0]       line_state,
   output logic             data_go
);
   initial begin
      if (LANES < 1 || LANES > 64)
         $error("LANES must lie in 1..64");
      if (CNT_W < 2 || CNT_W > 32)
         $error("CNT_W must lie in 2..32");
   end

   logic             all_lp, expired, load;
   logic [CNT_W-1:0] load_val;
   seq_state_e       state_q, state_d;

   cls_lane_monitor #(.LANES(LANES)) u_lanes (
      .data_lp (data_lp),
      .all_lp  (all_lp)
   );

   cls_interval_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   cls_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .hs_req   (hs_req),
      .all_lp   (all_lp),
      .expired  (expired),
      .t_lpx    (t_lpx),
      .t_prep   (t_prep),
      .t_zero   (t_zero),
      .t_pre    (t_pre),
      .t_post   (t_post),
      .t_trail  (t_trail),
      .t_exit   (t_exit),
      .load     (load),
      .load_val (load_val),
      .state_q  (state_q),
      .state_d  (state_d)
   );

   cls_out_stage #(.REG_OUT(REG_OUT)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .state_q    (state_q),
      .state_d    (state_d),
      .line_state (line_state),
      .data_go    (data_go)
   );
endmodule

// File: rtl/cls_checker.sv
module cls_checker #(
   parameter int LANES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hs_req,
   input logic [LANES-1:0] data_lp,
   input logic [2:0]       line_state,
   input logic             data_go
);
   a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      line_state <= 3'd4);

   a_r2_idle_exit_order: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state == 3'd0) |=> (line_state == 3'd0 || line_state == 3'd1));

   a_r3_lp01_order: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state == 3'd1) |=> (line_state == 3'd1 || line_state == 3'd2));

   a_r4_lp00_order: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state == 3'd2) |=> (line_state == 3'd2 || line_state == 3'd3));

   a_r9_hs0_order: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state == 3'd3) |=> (line_state != 3'd1 && line_state != 3'd2));

   a_r7_go_only_toggling: assert property (@(posedge clk) disable iff (!rst_n)
      data_go |-> (line_state == 3'd4));

   a_r7_go_falls: assert property (@(posedge clk) disable iff (!rst_n)
      (data_go && !hs_req) |=> !data_go);

   a_r6_lead_before_go: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_go) |-> ($past(line_state) == 3'd4 && !$past(data_go)));

   a_r8_hold_while_lane_hs: assert property (@(posedge clk) disable iff (!rst_n)
      (line_state == 3'd4 && !(&data_lp)) |=> (line_state == 3'd4));
endmodule

bind dphy_clk_lane_seq cls_checker #(.LANES(LANES)) u_cls_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .hs_req     (hs_req),
   .data_lp    (data_lp),
   .line_state (line_state),
   .data_go    (data_go)
);

// File: tb/tb_dphy_clk_lane_seq.sv
module tb_dphy_clk_lane_seq;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 4;
   localparam int CNT_W = 8;

   typedef struct {
      int lpx, prep, zero, pre, post, trail, ext;
   } cfg_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hs_req = 1'b0;
   logic [LANES-1:0] data_lp = '1;
   logic [CNT_W-1:0] t_lpx = '0, t_prep = '0, t_zero = '0, t_pre = '0;
   logic [CNT_W-1:0] t_post = '0, t_trail = '0, t_exit = '0;
   logic [2:0]       line_state;
   logic             data_go;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dphy_clk_lane_seq #(.LANES(LANES), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .data_lp(data_lp),
      .t_lpx(t_lpx), .t_prep(t_prep), .t_zero(t_zero), .t_pre(t_pre),
      .t_post(t_post), .t_trail(t_trail), .t_exit(t_exit),
      .line_state(line_state), .data_go(data_go)
   );

   function automatic int span(input int n);
      return (n == 0) ? 1 : n;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(input cfg_t c);
      t_lpx = CNT_W'(c.lpx);     t_prep = CNT_W'(c.prep);
      t_zero = CNT_W'(c.zero);   t_pre = CNT_W'(c.pre);
      t_post = CNT_W'(c.post);   t_trail = CNT_W'(c.trail);
      t_exit = CNT_W'(c.ext);
   endtask

   // counts consecutive samples with the given code (optionally go low)
   task automatic run_len(input int code, input bit go_low, output int n);
      n = 0;
      while (int'(line_state) == code && (!go_low || !data_go) && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   function automatic cfg_t rand_cfg();
      cfg_t c;
      c.lpx = int'($urandom_range(0, 12));  c.prep = int'($urandom_range(0, 12));
      c.zero = int'($urandom_range(0, 12)); c.pre = int'($urandom_range(0, 12));
      c.post = int'($urandom_range(0, 12)); c.trail = int'($urandom_range(0, 12));
      c.ext = int'($urandom_range(0, 12));
      return c;
   endfunction

   // one burst; caller is at a negedge. first: raise the request here.
   task automatic burst(input cfg_t c, input cfg_t nxt, input bit first,
                        input bit last, input int h);
      int n;
      if (first) begin
         apply(c);
         hs_req = 1'b1;
         @(negedge clk);
      end
      check("R2 LP-01 after request", int'(line_state), 1);
      run_len(1, 1'b0, n); check("R3 LP-01 length", n, span(c.lpx));
      check("R3 LP-00 follows", int'(line_state), 2);
      run_len(2, 1'b0, n); check("R4 LP-00 length", n, span(c.prep));
      check("R4 HS-0 follows", int'(line_state), 3);
      run_len(3, 1'b0, n); check("R5 HS-0 length", n, span(c.zero));
      run_len(4, 1'b1, n); check("R6 lead toggling length", n, span(c.pre));
      check("R6 go high", int'(data_go), 1);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
         @(negedge clk);
         check("R7 go held while running", int'(data_go), 1);
      end
      hs_req = 1'b0;
      data_lp = LANES'($urandom) & ~LANES'(1);
      @(negedge clk);
      check("R7 go falls after stop", int'(data_go), 0);
      for (int k = 1; k < h; k++) @(negedge clk);
      check("R8 toggling while lane busy", int'(line_state), 4);
      data_lp = '1;
      run_len(4, 1'b0, n); check("R8 post length", n, span(c.post));
      check("R9 trail HS-0", int'(line_state), 3);
      apply(nxt);
      if (!last) hs_req = 1'b1;
      run_len(3, 1'b0, n); check("R11 R9 trail length", n, span(c.trail));
      check("R9 LP-11 after trail", int'(line_state), 0);
      if (!last) begin
         run_len(0, 1'b0, n); check("R10 guard length", n, span(nxt.ext) + 1);
      end else begin
         n = 0;
         for (int k = 0; k < 40; k++) begin
            if (line_state == 3'd0 && !data_go) n++;
            @(negedge clk);
         end
         check("R2 idle holds LP-11", n, 40);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cfg_t c, nx;
      int unused;
      unused = int'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      check("R1 reset line", int'(line_state), 0);
      check("R1 reset go", int'(data_go), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R2 idle without request", int'(line_state), 0);

      // directed: all zero intervals, then all ones, then random
      c = '{0, 0, 0, 0, 0, 0, 0};
      nx = '{1, 1, 1, 1, 1, 1, 1};
      burst(c, nx, 1'b1, 1'b0, 1);
      c = nx;
      nx = '{12, 3, 7, 9, 12, 11, 5};
      burst(c, nx, 1'b0, 1'b0, 4);
      for (int i = 0; i < 10; i++) begin
         c = nx;
         nx = rand_cfg();
         burst(c, nx, 1'b0, 1'b0, int'($urandom_range(1, 6)));
      end
      c = nx;
      nx = '{0, 0, 0, 0, 0, 0, 0};
      burst(c, nx, 1'b0, 1'b1, 2);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule